// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a single-cycle internal 32-bit request port and an external asynchronous static memory built from four 8-bit dies. Every die has its own active-low enable and active-low write strobe. All dies share one active-low output enable and a 19-bit address. A requester presents an address, a write word, a 4-bit byte mask and a read/write flag while the controller reports ready. The controller then plays out the memory's timing windows, counted in system clock cycles, and ends each access with a one-cycle done pulse. For reads it also returns a registered data word.

The byte mask decides which dies take part, so the same port serves 8-, 16-, 24- and 32-bit accesses. Every timing window is given as a nanosecond parameter and converted to whole clock cycles, rounded up, for the configured clock period. In a write, the data bus is released for a short window after the strobe falls, so that it never drives against die outputs that might still be on. Every memory-side pin is driven from a flip-flop.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after synchronous reset, all enables and write strobes are high, the output enable is high, the data-bus drive flag is low, done is low and ready is high.
- R2: A read with a non-zero mask lowers `mem_en_n[i]` for each set mask bit i, lowers `mem_oe_n` and keeps all write strobes high. Lanes whose mask bit is clear return zero in `rdata`.
- R3: Read data is captured from `mem_dq_in` on the clock edge RD cycles after the accepting edge, where RD is the larger of the rounded-up access time and the rounded-up output-enable access time. Done is high in the cycle after that edge.
- R4: A write with a non-zero mask lowers `mem_en_n[i]` and `mem_we_n[i]` together for each set mask bit i. `mem_oe_n` stays high whenever any strobe is low.
- R5: The data bus is not driven while `mem_oe_n` is low. It is also not driven in the first cycle of a write strobe; driving begins only after the rounded-up turn-around delay.
- R6: A write strobe stays low for WP cycles. WP is the larger of the rounded-up pulse width and the turn-around delay plus the rounded-up data setup. The data bus is driven for at least the data-setup cycles before the strobe rises.
- R7: After the strobe rises, enables, address and driven data are held for the rounded-up hold time. Done is then high in the cycle after the last hold edge, so a write's done appears WP+HOLD edges after acceptance.
- R8: Done lasts exactly one cycle. Ready stays low for the rounded-up recovery time after each access (one cycle for a zero-mask access) and then returns high.
- R9: A request is taken only while ready is high. A request raised while busy is ignored and causes neither a memory write nor an extra done.
- R10: A request with an all-zero mask causes no enable or strobe activity. Its done appears in the cycle right after acceptance, and a zero-mask read returns zero.
- R11: The address does not change while any enable is low.
- R12: Mask bit i controls lane i, which is data bits [8i+7:8i] and the pair `mem_en_n[i]`/`mem_we_n[i]`. A write leaves unselected bytes of the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write word |
| req_mask | input | 4 | Byte-lane select, bit i = lane i |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 32 | Registered read word, masked lanes zero |
| mem_addr | output | 19 | Shared memory address |
| mem_en_n | output | 4 | Per-lane active-low enable |
| mem_we_n | output | 4 | Per-lane active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_out | output | 32 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable for `mem_dq_out` |
| mem_dq_in | input | 32 | Data sensed on the bus |

## Verification
The assertions watch pin relations that must hold on every cycle. They check that the output enable is high during strobes, that no strobe is low without its enable, that the bus is never driven against an active output enable or in a strobe's first cycle, and that strobe width is at least WP. They also check the hold of enable and data at strobe rise, address stability under enable, done lasting one cycle, and done never coinciding with ready. The bench's scenarios cover what only a memory model can show: byte-merge results for several masks, zeroed lanes in partial reads, exact read and write latencies, the recovery gap, zero-mask completion without strobes, and a request raised while busy leaving memory untouched.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_WLEAD = 3'd2,
    ST_WDATA = 3'd3,
    ST_WHOLD = 3'd4,
    ST_GAP   = 3'd5,
    ST_SKIP  = 3'd6
  } st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int r;
    r = (ns + clk_ns - 1) / clk_ns;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CNT_W    = 2,
  parameter int RD_CYC   = 2,
  parameter int DLY_CYC  = 1,
  parameter int WDAT_CYC = 1,
  parameter int HOLD_CYC = 1,
  parameter int GAP_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             mask_zero,
  input  logic             tmr_zero,
  output logic             ready,
  output logic             done,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             en_nxt,
  output logic             we_nxt,
  output logic             oe_nxt,
  output logic             drv_nxt,
  output logic             capture,
  output logic             clear
);

  st_e  st, nxt;
  logic fin;

  assign accept = ready & req_valid;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    fin      = 1'b0;
    capture  = 1'b0;
    clear    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          if (mask_zero) begin
            nxt   = ST_SKIP;
            clear = ~req_write;
          end else if (req_write) begin
            nxt      = ST_WLEAD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(DLY_CYC - 1);
          end else begin
            nxt      = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          nxt      = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(GAP_CYC - 1);
          capture  = 1'b1;
          fin      = 1'b1;
        end
      end
      ST_WLEAD: begin
        if (tmr_zero) begin
          nxt      = ST_WDATA;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WDAT_CYC - 1);
        end
      end
      ST_WDATA: begin
        if (tmr_zero) begin
          nxt      = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (tmr_zero) begin
          nxt      = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(GAP_CYC - 1);
          fin      = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_zero) nxt = ST_IDLE;
      end
      ST_SKIP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // control levels for the state being entered; registered downstream
  assign en_nxt  = (nxt == ST_RD) || (nxt == ST_WLEAD) ||
                   (nxt == ST_WDATA) || (nxt == ST_WHOLD);
  assign we_nxt  = (nxt == ST_WLEAD) || (nxt == ST_WDATA);
  assign oe_nxt  = (nxt == ST_RD);
  assign drv_nxt = (nxt == ST_WDATA) || (nxt == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ready <= 1'b1;
      done  <= 1'b0;
    end else begin
      st    <= nxt;
      ready <= (nxt == ST_IDLE);
      done  <= fin | (accept & mask_zero);
    end
  end

endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] mask_nxt,
  input  logic [LANES-1:0] mask_q,
  input  logic             en_nxt,
  input  logic             we_nxt,
  input  logic             capture,
  input  logic             clear,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] en_n,
  output logic [LANES-1:0] we_n,
  output logic [DW-1:0]    rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        en_n[g] <= 1'b1;
        we_n[g] <= 1'b1;
        rdata[g*LANE_W +: LANE_W] <= '0;
      end else begin
        en_n[g] <= ~(en_nxt & mask_nxt[g]);
        we_n[g] <= ~(we_nxt & mask_nxt[g]);
        if (clear) begin
          rdata[g*LANE_W +: LANE_W] <= '0;
        end else if (capture) begin
          rdata[g*LANE_W +: LANE_W] <= mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int T_ACC_NS   = 17,
  parameter int T_OE_NS    = 7,
  parameter int T_WP_NS    = 12,
  parameter int T_TURN_NS  = 5,
  parameter int T_DSU_NS   = 7,
  parameter int T_HOLD_NS  = 2,
  parameter int T_GAP_NS   = 3,
  localparam int DW        = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_en_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic              mem_oe_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);

  localparam int RD_CYC   = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int DLY_CYC  = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int DSU_CYC  = ns_to_cyc(T_DSU_NS, CLK_NS);
  localparam int WP_CYC   = imax(ns_to_cyc(T_WP_NS, CLK_NS), DLY_CYC + DSU_CYC);
  localparam int WDAT_CYC = WP_CYC - DLY_CYC;
  localparam int HOLD_CYC = ns_to_cyc(T_HOLD_NS, CLK_NS);
  localparam int GAP_CYC  = ns_to_cyc(T_GAP_NS, CLK_NS);
  localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(HOLD_CYC, GAP_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             accept, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             en_nxt, we_nxt, oe_nxt, drv_nxt, capture, clear;
  logic [LANES-1:0] mask_q, mask_nxt;
  logic             mask_zero;

  assign mask_zero = (req_mask == '0);
  assign mask_nxt  = accept ? req_mask : mask_q;

  sramc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sramc_seq #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .DLY_CYC  (DLY_CYC),
    .WDAT_CYC (WDAT_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .mask_zero (mask_zero),
    .tmr_zero  (tmr_zero),
    .ready     (req_ready),
    .done      (done),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .en_nxt    (en_nxt),
    .we_nxt    (we_nxt),
    .oe_nxt    (oe_nxt),
    .drv_nxt   (drv_nxt),
    .capture   (capture),
    .clear     (clear)
  );

  sramc_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .mask_nxt (mask_nxt),
    .mask_q   (mask_q),
    .en_nxt   (en_nxt),
    .we_nxt   (we_nxt),
    .capture  (capture),
    .clear    (clear),
    .dq_in    (mem_dq_in),
    .en_n     (mem_en_n),
    .we_n     (mem_we_n),
    .rdata    (rdata)
  );

  // shared pins and request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      mem_oe_n  <= ~oe_nxt;
      mem_dq_oe <= drv_nxt;
      if (accept && !mask_zero) begin
        mask_q   <= req_mask;
        mem_addr <= req_addr;
        if (req_write) mem_dq_out <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
  import sramc_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int LANES     = 4,
  parameter int CLK_NS    = 10,
  parameter int T_WP_NS   = 12,
  parameter int T_TURN_NS = 5,
  parameter int T_DSU_NS  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_en_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int WP_MIN = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                               ns_to_cyc(T_TURN_NS, CLK_NS) + ns_to_cyc(T_DSU_NS, CLK_NS));

  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= 0;
    else if (!(&mem_we_n)) low_run <= low_run + 1;
    else low_run <= 0;
  end

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    !(&mem_we_n) |-> mem_oe_n);

  assert_strobe_needs_enable_R12: assert property (@(posedge clk) disable iff (rst)
    ((~mem_we_n) & mem_en_n) == '0);

  assert_no_drive_first_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(&mem_we_n) |-> !mem_dq_oe);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
    ((low_run != 0) && (&mem_we_n)) |-> (low_run >= WP_MIN));

  assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(&mem_we_n) |-> (mem_dq_oe && !(&mem_en_n)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (!(&mem_en_n) && $past(!(&mem_en_n))) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .CLK_NS    (CLK_NS),
  .T_WP_NS   (T_WP_NS),
  .T_TURN_NS (T_TURN_NS),
  .T_DSU_NS  (T_DSU_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_en_n  (mem_en_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int CLK_NS = 10;

  function automatic int cyc(input int ns);
    int r;
    r = (ns + CLK_NS - 1) / CLK_NS;
    return (r < 1) ? 1 : r;
  endfunction

  localparam int RD_EXP   = (cyc(17) > cyc(7)) ? cyc(17) : cyc(7);
  localparam int WP_EXP   = (cyc(12) > cyc(5) + cyc(7)) ? cyc(12) : cyc(5) + cyc(7);
  localparam int HOLD_EXP = cyc(2);
  localparam int GAP_EXP  = cyc(3);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [18:0] mem_addr;
  logic [3:0]  mem_en_n, mem_we_n;
  logic        mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .mem_addr(mem_addr), .mem_en_n(mem_en_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model: 64 words, byte lanes written on strobe rise
  logic [31:0] mem [64];
  logic [3:0]  prev_we = 4'hF;
  int falls = 0, run = 0, last_run = 0, early = 0, contend = 0, undriven = 0;

  always_comb begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[i*8 +: 8] = (!mem_en_n[i] && mem_we_n[i] && !mem_oe_n)
                            ? mem[mem_addr[5:0]][i*8 +: 8] : 8'h5A;
  end

  always @(negedge clk) begin
    if (&prev_we && !(&mem_we_n)) begin
      falls = falls + 1;
      run = 1;
      if (mem_dq_oe) early = early + 1;
    end else if (!(&mem_we_n)) begin
      run = run + 1;
    end
    if (!(&prev_we) && (&mem_we_n)) last_run = run;
    if (mem_dq_oe && !mem_oe_n) contend = contend + 1;
    for (int i = 0; i < 4; i++) begin
      if (!prev_we[i] && mem_we_n[i] && !mem_en_n[i]) begin
        if (!mem_dq_oe) undriven = undriven + 1;
        mem[mem_addr[5:0]][i*8 +: 8] = mem_dq_out[i*8 +: 8];
      end
    end
    prev_we = mem_we_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [18:0] a, input logic [31:0] d,
                        input logic [3:0] m, output logic [31:0] rd);
    int lat;
    int exp_lat;
    bit first;
    bit seen;
    @(negedge clk);
    check(req_ready === 1'b1, "R9 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0; first = 1; seen = 0;
    while (!seen && lat < 40) begin
      @(negedge clk);
      if (first && m != 0) begin
        if (wr) begin
          check(mem_en_n == ~m && mem_we_n == ~m, "R4 write lane pins", {mem_en_n, mem_we_n}, {~m, ~m});
          check(mem_oe_n && !mem_dq_oe, "R5 bus released at strobe start", {mem_oe_n, mem_dq_oe}, 2'b10);
        end else begin
          check(mem_en_n == ~m && mem_we_n == 4'hF && !mem_oe_n, "R2 read pins",
                {mem_en_n, mem_we_n, mem_oe_n}, {~m, 4'hF, 1'b0});
        end
      end
      first = 0;
      if (done) seen = 1;
      else lat++;
    end
    rd = rdata;
    exp_lat = (m == 0) ? 0 : (wr ? WP_EXP + HOLD_EXP : RD_EXP);
    check(seen && lat == exp_lat, wr ? "R7 write done latency" : "R3 read done latency", lat, exp_lat);
    check(!req_ready, "R8 busy during recovery", {31'd0, req_ready}, 32'd0);
    repeat ((m == 0) ? 1 : GAP_EXP) @(negedge clk);
    check(req_ready && !done, "R8 ready after recovery, done one cycle", {req_ready, done}, 2'b10);
  endtask

  task automatic t_reset();
    check(mem_en_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe && !done && req_ready,
          "R1 reset pins", {mem_en_n, mem_we_n, mem_oe_n, mem_dq_oe, done, req_ready},
          {4'hF, 4'hF, 4'b1001});
  endtask

  task automatic t_full_word();
    logic [31:0] r;
    int f0;
    f0 = falls;
    access(1, 19'd5, 32'hDEADBEEF, 4'hF, r);
    check(falls == f0 + 1, "R4 one strobe pulse", falls - f0, 1);
    check(last_run == WP_EXP, "R6 strobe width", last_run, WP_EXP);
    access(0, 19'd5, 32'h0, 4'hF, r);
    check(r == 32'hDEADBEEF, "R2 full word read", r, 32'hDEADBEEF);
  endtask

  task automatic t_byte_lanes();
    logic [31:0] r;
    access(1, 19'd9, 32'h11223344, 4'hF, r);
    access(1, 19'd9, 32'hAABBCCDD, 4'b0100, r);
    access(0, 19'd9, 32'h0, 4'hF, r);
    check(r == 32'h11BB3344, "R12 single lane merge", r, 32'h11BB3344);
    access(1, 19'd9, 32'h99885566, 4'b0011, r);
    access(0, 19'd9, 32'h0, 4'hF, r);
    check(r == 32'h11BB5566, "R12 half word merge", r, 32'h11BB5566);
    access(1, 19'd9, 32'h77000000, 4'b1000, r);
    access(0, 19'd9, 32'h0, 4'hF, r);
    check(r == 32'h77BB5566, "R12 top lane merge", r, 32'h77BB5566);
  endtask

  task automatic t_partial_read();
    logic [31:0] r;
    access(0, 19'd9, 32'h0, 4'b1010, r);
    check(r == 32'h77005500, "R2 masked lanes zero", r, 32'h77005500);
    access(0, 19'd9, 32'h0, 4'b0001, r);
    check(r == 32'h00000066, "R2 single lane read", r, 32'h00000066);
  endtask

  task automatic t_zero_mask();
    logic [31:0] r;
    int f0;
    f0 = falls;
    access(1, 19'd9, 32'hFFFFFFFF, 4'h0, r);
    check(falls == f0, "R10 no strobe on zero mask", falls - f0, 0);
    access(0, 19'd5, 32'h0, 4'hF, r);
    access(0, 19'd9, 32'h0, 4'h0, r);
    check(r == 32'h0, "R10 zero mask read returns zero", r, 32'h0);
    access(0, 19'd9, 32'h0, 4'hF, r);
    check(r == 32'h77BB5566, "R10 word unchanged", r, 32'h77BB5566);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    int extra;
    int waitc;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'd12; req_wdata = 32'h01020304; req_mask = 4'hF;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R9 busy after accept", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!done && waitc < 40) begin
      @(negedge clk);
      waitc++;
    end
    extra = 0;
    repeat (8) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R9 no done for ignored request", extra, 0);
    access(0, 19'd12, 32'h0, 4'hF, r);
    check(r == 32'h01020304, "R9 ignored request wrote nothing", r, 32'h01020304);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_byte_lanes();
    t_partial_read();
    t_zero_mask();
    t_busy_ignore();
    check(contend == 0, "R5 no bus contention", contend, 0);
    check(early == 0, "R5 no drive in first strobe cycle", early, 0);
    check(undriven == 0, "R6 data driven at strobe rise", undriven, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule